// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block is the master for a small three-wire serial EEPROM holding 64 words of 16 bits. A client issues one request at a time, either a word read or a word write with a 6-bit word address. The block then produces every chip-select, clock and data-in transition on the serial pins and samples the data-out pin. When the operation is over it reports with a one-cycle done pulse. It returns the read word, or a timeout flag if a write never completed.

Every serial pin change is followed by one half-period of the serial clock, and that half-period is a parameter counted in system clocks. A read sends its opcode and address, clocks in sixteen bits and leaves the memory in standby. A write is wrapped in an enable command and a disable command, with standby toggles of chip select between the steps. Write completion is found by polling data-out for a high level within a bounded number of checks. A request that arrives while the block is busy is dropped.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is asserted and after it, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `rsp_done` and `rsp_timeout` are all low.
- R2: A read shifts out the 9-bit frame 110 followed by the address, most significant bit first. For each bit, data-in is set first, then the clock is raised, then it is lowered, and data-in never changes while the clock is high.
- R3: A read then gives 16 clock pulses. It samples `ee_do` while the clock is high, just before lowering it, and shifts each bit in at the least significant end. The first bit received ends up as bit 15 of `rsp_rdata`.
- R4: Data-in stays low while bits are shifted in. It is driven low again on the same step that lowers the clock after the last bit of every shift-out burst.
- R5: Every operation starts with a setup step that leaves chip select high and both clock and data-in low.
- R6: A standby sequence is four steps in this order: chip select and clock low together, clock high, chip select high, clock low.
- R7: A write runs in this order: setup; frame 10011 plus four zero bits; standby; frame 101, address, then 16 data bits; standby; completion polling; standby; frame 10000 plus four zero bits; cleanup.
- R8: Polling samples `ee_do` once per half-period, starting one half-period after the preceding standby. The first high sample ends polling at once, and `rsp_timeout` then stays low.
- R9: If `ee_do` is low on all POLL_LIMIT samples (200 by default), `rsp_timeout` is raised. The write still goes on through standby, the disable frame and cleanup.
- R10: Cleanup drops chip select and data-in, then gives one clock pulse (high, then low). A write therefore ends with all three serial outputs low.
- R11: A read ends with a standby sequence, not a cleanup, so it leaves chip select high and clock low.
- R12: Serial outputs change only on half-period boundaries. Step n of an operation takes effect n×HALF_CLKS clocks after the edge that accepted the request.
- R13: A request arriving while `busy` is high is ignored. The running operation's pin sequence and result do not change, and no second operation follows.
- R14: `rsp_done` is high for exactly one clock, on the same edge as the final serial step, and `busy` falls on that edge too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Operation in progress |
| rsp_done | output | 1 | One-cycle end-of-operation pulse |
| rsp_rdata | output | 16 | Last word read, held until the next read ends |
| rsp_timeout | output | 1 | Write completion timed out; cleared on the next accepted request |
| ee_cs | output | 1 | Serial memory chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
Reads are swept over all 64 addresses, each returning a different 16-bit pattern, plus all-zero and all-ones words. This separates address-bit ordering errors from data-bit ordering and sampling-edge errors. Writes use all-ones, all-zero and alternating data, and the polling input goes high on the first sample, on a middle sample, on the last allowed sample and never. This separates the off-by-one cases of the poll bound from the timeout path. A request injected in the middle of a read shows whether anything reaches the running sequence.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int FW = 3 + AW + DW;   // longest outgoing frame
  localparam int CMDW = 9;           // short command frames

  localparam logic [2:0] OP_READ  = 3'b110;
  localparam logic [2:0] OP_WRITE = 3'b101;
  localparam logic [4:0] OP_WREN  = 5'b10011;
  localparam logic [4:0] OP_WRDIS = 5'b10000;

  typedef enum logic [2:0] {
    K_SETUP, K_OUT, K_IN, K_STBY, K_POLL, K_CLEAN, K_END
  } seg_kind_e;

  // segment program of each operation
  function automatic seg_kind_e seg_kind(input logic wr, input logic [3:0] s);
    if (!wr) begin
      case (s)
        4'd0: return K_SETUP;
        4'd1: return K_OUT;
        4'd2: return K_IN;
        4'd3: return K_STBY;
        default: return K_END;
      endcase
    end
    case (s)
      4'd0: return K_SETUP;
      4'd1, 4'd3, 4'd7: return K_OUT;
      4'd2, 4'd4, 4'd6: return K_STBY;
      4'd5: return K_POLL;
      4'd8: return K_CLEAN;
      default: return K_END;
    endcase
  endfunction

  // outgoing frame of a segment, left aligned
  function automatic logic [FW-1:0] seg_load(input logic wr, input logic [3:0] s,
                                             input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!wr) return (s == 4'd1) ? {OP_READ, a, {DW{1'b0}}} : '0;
    case (s)
      4'd1: return {OP_WREN, 4'b0000, {DW{1'b0}}};
      4'd3: return {OP_WRITE, a, d};
      4'd7: return {OP_WRDIS, 4'b0000, {DW{1'b0}}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [4:0] seg_len(input logic wr, input logic [3:0] s);
    return (wr && s == 4'd3) ? 5'(FW) : 5'(CMDW);
  endfunction
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int HALF_CLKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CLKS - 1);

  logic [TW-1:0] cnt_q, cnt_n;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (!en || tick) cnt_n = '0;
    else             cnt_n = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  generate
    if (HALF_CLKS > 1) begin : g_gap
      p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int POLL_LIMIT = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ee_do,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] rdata,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di
);
  localparam int CW = $clog2((POLL_LIMIT > FW) ? POLL_LIMIT : FW);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_LIMIT - 1);
  localparam logic [CW-1:0] IN_LAST   = CW'(DW - 1);

  logic          busy_q, busy_n, wr_q, wr_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wdata_q, wdata_n, rsh_q, rsh_n, rdata_q, rdata_n;
  logic [3:0]    seg_q, seg_n;
  logic [1:0]    ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n, out_last;
  logic [FW-1:0] sh_q, sh_n;
  logic          cs_q, cs_n, sk_q, sk_n, di_q, di_n;
  logic          done_q, done_n, err_q, err_n, adv;
  seg_kind_e     kind, nxt_kind;

  assign kind     = seg_kind(wr_q, seg_q);
  assign nxt_kind = seg_kind(wr_q, seg_q + 4'd1);
  assign out_last = CW'(seg_len(wr_q, seg_q)) - CW'(1);

  always_comb begin
    busy_n = busy_q; wr_n = wr_q; addr_n = addr_q; wdata_n = wdata_q;
    seg_n = seg_q; ph_n = ph_q; cnt_n = cnt_q; sh_n = sh_q;
    rsh_n = rsh_q; rdata_n = rdata_q;
    cs_n = cs_q; sk_n = sk_q; di_n = di_q;
    err_n = err_q; done_n = 1'b0; adv = 1'b0;
    if (!busy_q) begin
      if (req_valid) begin
        busy_n = 1'b1; wr_n = req_write; addr_n = req_addr; wdata_n = req_wdata;
        seg_n = '0; ph_n = '0; cnt_n = '0; err_n = 1'b0;
      end
    end else if (tick) begin
      case (kind)
        K_SETUP: begin
          sk_n = 1'b0; di_n = 1'b0; cs_n = 1'b1; adv = 1'b1;
        end
        K_OUT: begin
          case (ph_q)
            2'd0: begin di_n = sh_q[FW-1]; ph_n = 2'd1; end
            2'd1: begin sk_n = 1'b1; ph_n = 2'd2; end
            default: begin
              sk_n = 1'b0;
              sh_n = sh_q << 1;
              if (cnt_q == out_last) begin di_n = 1'b0; adv = 1'b1; end
              else begin cnt_n = cnt_q + CW'(1); ph_n = 2'd0; end
            end
          endcase
        end
        K_IN: begin
          if (ph_q == 2'd0) begin sk_n = 1'b1; ph_n = 2'd1; end
          else begin
            sk_n  = 1'b0;
            rsh_n = {rsh_q[DW-2:0], ee_do};
            if (cnt_q == IN_LAST) adv = 1'b1;
            else begin cnt_n = cnt_q + CW'(1); ph_n = 2'd0; end
          end
        end
        K_STBY: begin
          case (ph_q)
            2'd0: begin cs_n = 1'b0; sk_n = 1'b0; ph_n = 2'd1; end
            2'd1: begin sk_n = 1'b1; ph_n = 2'd2; end
            2'd2: begin cs_n = 1'b1; ph_n = 2'd3; end
            default: begin sk_n = 1'b0; adv = 1'b1; end
          endcase
        end
        K_POLL: begin
          if (ee_do) adv = 1'b1;
          else if (cnt_q == POLL_LAST) begin err_n = 1'b1; adv = 1'b1; end
          else cnt_n = cnt_q + CW'(1);
        end
        K_CLEAN: begin
          case (ph_q)
            2'd0: begin cs_n = 1'b0; di_n = 1'b0; ph_n = 2'd1; end
            2'd1: begin sk_n = 1'b1; ph_n = 2'd2; end
            default: begin sk_n = 1'b0; adv = 1'b1; end
          endcase
        end
        default: busy_n = 1'b0;
      endcase
      if (adv) begin
        seg_n = seg_q + 4'd1; ph_n = '0; cnt_n = '0;
        sh_n  = seg_load(wr_q, seg_q + 4'd1, addr_q, wdata_q);
        if (nxt_kind == K_END) begin
          busy_n = 1'b0; done_n = 1'b1;
          if (!wr_q) rdata_n = rsh_n;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wr_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
      seg_q <= '0; ph_q <= '0; cnt_q <= '0; sh_q <= '0;
      rsh_q <= '0; rdata_q <= '0;
      cs_q <= 1'b0; sk_q <= 1'b0; di_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      busy_q <= busy_n; wr_q <= wr_n; addr_q <= addr_n; wdata_q <= wdata_n;
      seg_q <= seg_n; ph_q <= ph_n; cnt_q <= cnt_n; sh_q <= sh_n;
      rsh_q <= rsh_n; rdata_q <= rdata_n;
      cs_q <= cs_n; sk_q <= sk_n; di_q <= di_n;
      done_q <= done_n; err_q <= err_n;
    end
  end

  assign busy = busy_q; assign done = done_q; assign timeout = err_q;
  assign rdata = rdata_q;
  assign ee_cs = cs_q; assign ee_sk = sk_q; assign ee_di = di_q;

  p_di_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_q && $past(sk_q)) |-> (di_q == $past(di_q)));
  p_di_low_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind == K_IN) |-> !di_q);
  p_err_from_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(kind == K_POLL));
  p_idle_sk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sk_q);
  p_pins_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({cs_q, sk_q, di_q}));
  p_ignore_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_valid) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));
  p_done_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int HALF_CLKS  = 5000,
  parameter int POLL_LIMIT = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n, tick, busy_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  mw_half_timer #(.HALF_CLKS(HALF_CLKS)) timer_i (
    .clk(clk), .rst_n(rst_sync_n), .en(busy_w), .tick(tick)
  );

  mw_seq #(.POLL_LIMIT(POLL_LIMIT)) seq_i (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ee_do(ee_do),
    .busy(busy_w), .done(rsp_done), .timeout(rsp_timeout), .rdata(rsp_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
  );

  assign busy = busy_w;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!ee_cs && !ee_sk && !ee_di && !busy_w && !rsp_done));
endmodule

// File: tb/mw_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int PLIM = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic ee_do = 1'b0;
  logic busy, rsp_done, rsp_timeout, ee_cs, ee_sk, ee_di;
  logic [15:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [2:0] e_pin [0:1023];
  logic       e_do  [0:1023];
  int n_st;

  always #5 clk = ~clk;

  mw_eeprom_ctrl #(.HALF_CLKS(HALF), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  wire [2:0] pins = {ee_cs, ee_sk, ee_di};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic c, input logic k, input logic d, input logic o);
    e_pin[n_st] = {c, k, d};
    e_do[n_st]  = o;
    n_st++;
  endtask

  // MSB first; data-in set, clock up, clock down; low after last bit
  task automatic push_out(input logic [24:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      push(1, 0, v[i], 0);
      push(1, 1, v[i], 0);
      push(1, 0, (i == 0) ? 1'b0 : v[i], 0);
    end
  endtask

  task automatic push_stby();
    push(0, 0, 0, 0); push(0, 1, 0, 0); push(1, 1, 0, 0); push(1, 0, 0, 0);
  endtask

  task automatic run_cmd(input logic wr, input logic [5:0] a, input logic [15:0] d,
                         input int poll_at, input bit inject);
    int first_bad = -1, stab_bad = 0, done_bad = 0;
    logic [2:0] bad_act = '0, bad_exp = '0, prev, obs0, obs;
    n_st = 0;
    push(1, 0, 0, 0);
    if (!wr) begin
      push_out({16'h0, 3'b110, a}, 9);
      for (int i = 15; i >= 0; i--) begin push(1, 1, 0, 0); push(1, 0, 0, d[i]); end
      push_stby();
    end else begin
      push_out({16'h0, 5'b10011, 4'b0000}, 9);
      push_stby();
      push_out({3'b101, a, d}, 25);
      push_stby();
      for (int k = 1; k <= PLIM; k++) begin
        if (poll_at == k) begin push(1, 0, 0, 1); break; end
        push(1, 0, 0, 0);
      end
      push_stby();
      push_out({16'h0, 5'b10000, 4'b0000}, 9);
      push(0, 0, 0, 0); push(0, 1, 0, 0); push(0, 0, 0, 0);
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    prev = pins; obs0 = '0; obs = '0;
    for (int n = 0; n < n_st; n++) begin
      ee_do = e_do[n];
      for (int c = 0; c < HALF - 1; c++) begin
        @(posedge clk); @(negedge clk);
        if (pins !== prev || rsp_done !== 1'b0) stab_bad++;
      end
      @(posedge clk); @(negedge clk);
      obs = pins;
      if (n == 0) obs0 = obs;
      if (obs !== e_pin[n] && first_bad < 0) begin
        first_bad = n; bad_act = obs; bad_exp = e_pin[n];
      end
      if (rsp_done !== (n == n_st - 1)) done_bad++;
      prev = obs;
      if (inject && n == 5) begin
        req_valid = 1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      end else if (inject && n == 6) req_valid = 0;
    end
    ee_do = 0;
    if (!wr) check(first_bad < 0, "R2 R4 R6", $sformatf("read trace step %0d", first_bad), bad_act, bad_exp);
    else     check(first_bad < 0, "R7 R6 R10", $sformatf("write trace step %0d", first_bad), bad_act, bad_exp);
    check(stab_bad == 0, "R12", "pins moved inside a half-period", stab_bad, 0);
    check(done_bad == 0, "R14", "done placement", done_bad, 0);
    check(obs0 == 3'b100, "R5", "setup pins", obs0, 3'b100);
    @(negedge clk);
    check(rsp_done == 0 && busy == 0, "R14", "done/busy after end", {rsp_done, busy}, 0);
    if (!wr) begin
      check(rsp_rdata == d, "R3", "read word", rsp_rdata, d);
      check(pins == 3'b100, "R11", "pins after read", pins, 3'b100);
    end else begin
      if (poll_at == 0) check(rsp_timeout == 1, "R9", "timeout flag", rsp_timeout, 1);
      else              check(rsp_timeout == 0, "R8", "timeout flag", rsp_timeout, 0);
      check(pins == 3'b000, "R10", "pins after write", pins, 3'b000);
    end
    if (inject) begin
      repeat (8) @(negedge clk);
      check(busy == 0 && rsp_done == 0, "R13", "no follow-on operation", busy, 0);
      check(rsp_rdata == d, "R13", "result kept", rsp_rdata, d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, rsp_done, rsp_timeout} == 0, "R1", "outputs in reset",
          {ee_cs, ee_sk, ee_di, busy, rsp_done, rsp_timeout}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, rsp_done, rsp_timeout} == 0, "R1", "outputs after reset",
          {ee_cs, ee_sk, ee_di, busy, rsp_done, rsp_timeout}, 0);
    // R2 R3: sweep every address, distinct word per address
    for (int a = 0; a < 64; a++)
      run_cmd(0, 6'(a), 16'(a * 16'h9E37) ^ 16'h5A5A, 0, 0);
    run_cmd(0, 6'h15, 16'h0000, 0, 0);
    run_cmd(0, 6'h2A, 16'hFFFF, 0, 0);
    // R7 R8 R9: writes with poll success early, middle, last sample, never
    run_cmd(1, 6'h00, 16'hFFFF, 1, 0);
    run_cmd(1, 6'h3F, 16'h0000, 7, 0);
    run_cmd(1, 6'h15, 16'h5555, PLIM, 0);
    run_cmd(1, 6'h2A, 16'hAAAA, 0, 0);
    run_cmd(1, 6'h01, 16'h8001, 3, 0);
    // R13: request injected during a read
    run_cmd(0, 6'h33, 16'hC3A5, 0, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule